// File: doc/BRIEF.md
# Full-Duplex Serial Shift Data Register

This block is the data path of a serial peripheral port. A bus write loads a transmit character into a 16-bit shift register. Each shift strobe from the port's timing logic then sends one bit out and captures one bit in. The received bits enter at bit 0. The transmitted bits leave from a tap whose position depends on the character length. For lengths of 9 to 16 bits the tap is bit 15. For lengths of 8 or fewer the tap moves to bit 7, so a short character is placed as in a byte-wide register, starting at bit 7 and going down.

A bit counter tracks how many shifts remain. When the last bit of a character has been exchanged, the block copies the low character-length bits of the shift register into a separate receive buffer. It pulses a completion strobe for one cycle and sets a sticky full flag, which a buffer read clears. Software reads received data only from this buffer, because the live shift register holds mixed data during a transfer.

An enable input gates everything. While it is low, bus writes are dropped and the shift register is held at zero. Dropping it mid-transfer abandons the character.

Top module: `spi_shift_core`

## Requirements
- R1: After reset `sout`, `busy`, `rx_done`, `rx_full` and `rx_data` are all 0.
- R2: A bus write while `enable` is 1 and `busy` is 0 loads `wr_data[15:0]` into the shift register and raises `busy`. `wr_data[31:16]` has no effect on any output. `busy` stays high until the edge of the final shift.
- R3: A bus write while `enable` is 0 is dropped. The register stays zero and no transfer starts.
- R4: A bus write while `busy` is 1 is dropped. The character in flight is sent unchanged.
- R5: For an effective length of 9 to 16, `sout` shows bit 15, so the loaded word goes out most significant bit first.
- R6: For an effective length of 1 to 8, `sout` shows bit 7. The bits sent are loaded bit 7 first, then bit 6, and so on downward for the length.
- R7: Each `shift_strb` while `busy` shifts the register left by one, with `sin` entering bit 0. A strobe while idle changes nothing.
- R8: `char_len` is sampled at the accepted write. The value 0, and any value above 16, means 16. The transfer ends after exactly that many strobes.
- R9: In the cycle after the final shift edge, `rx_done` is 1 for exactly one cycle. `rx_data` then holds the low length bits of the shifted register, zero-extended. The first bit received is the most significant of these. `rx_data` changes at no other time.
- R10: `rx_full` is set with `rx_done` and stays set until a cycle with `rx_rd` high. If a completion and `rx_rd` fall in the same cycle, the completion wins and the flag stays set.
- R11: Driving `enable` to 0 clears the shift register, so `sout` becomes 0. It also ends any transfer without `rx_done`, while the receive buffer keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low clears the register and drops writes |
| char_len | input | 5 | Character length, 1 to 16 (0 means 16) |
| wr_en | input | 1 | Bus write strobe for the shift register |
| wr_data | input | 32 | Bus write data; only bits 15:0 are used |
| shift_strb | input | 1 | One-cycle strobe per bit from the timing logic |
| sin | input | 1 | Serial input |
| sout | output | 1 | Serial output from the length-dependent tap |
| busy | output | 1 | Transfer in progress |
| rx_data | output | 16 | Receive buffer |
| rx_done | output | 1 | One-cycle pulse when a character completes |
| rx_full | output | 1 | Sticky flag: receive buffer holds unread data |
| rx_rd | input | 1 | Buffer read strobe; clears `rx_full` |

## Verification
The bound checker watches, on every cycle, the protocol relations of the control outputs:
- disabling clears `busy` and `sout`;
- writes while disabled start nothing;
- `rx_done` is a single-cycle pulse that follows the fall of `busy` and comes with `rx_full`;
- `rx_data` moves only with `rx_done`;
- a read clears the flag unless a completion coincides with it.

The bit-level content can only be shown by the bench's scenarios. These cover the serial order at each tap position, the received value for several lengths including the 0-means-16 case, and the survival of the in-flight character across a write during a transfer. They also cover idle strobes, an aborted transfer and a read that coincides with a completion.

// File: rtl/spi_sdr_pkg.sv
package spi_sdr_pkg;

  // Which register bit feeds the serial output
  typedef enum logic {
    TAP_WIDE   = 1'b0,
    TAP_NARROW = 1'b1
  } tap_e;

  // Map a raw character length to the number of bits actually moved:
  // zero or out-of-range values select the full register width.
  function automatic int unsigned eff_len(input int unsigned raw,
                                          input int unsigned maxw);
    if (raw == 0 || raw > maxw) return maxw;
    return raw;
  endfunction

  function automatic tap_e pick_tap(input int unsigned len,
                                    input int unsigned narrow_w);
    return (len <= narrow_w) ? TAP_NARROW : TAP_WIDE;
  endfunction

endpackage

// File: rtl/sdr_bitcnt.sv
module sdr_bitcnt
  import spi_sdr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LEN_W    = 5,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             strobe,
  output logic             busy,
  output logic             shift_en,
  output logic             last_shift,
  output logic [LEN_W-1:0] len_q,
  output tap_e             tap_q
);

  localparam int CNT_W = LEN_W;

  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_eff;

  assign len_eff    = LEN_W'(eff_len(int'(len_in), DATA_W));
  assign shift_en   = busy && strobe && enable;
  assign last_shift = shift_en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= len_eff;
      busy  <= 1'b1;
    end else if (shift_en) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_W'(DATA_W);
      tap_q <= TAP_WIDE;
    end else if (start) begin
      len_q <= len_eff;
      tap_q <= pick_tap(int'(len_eff), NARROW_W);
    end
  end

endmodule

// File: rtl/sdr_shifter.sv
module sdr_shifter
  import spi_sdr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              sin,
  input  tap_e              tap,
  output logic              sout,
  output logic [DATA_W-1:0] shifted
);

  localparam int WIDE_BIT   = DATA_W - 1;
  localparam int NARROW_BIT = NARROW_W - 1;

  logic [DATA_W-1:0] sreg_q;

  assign shifted = {sreg_q[DATA_W-2:0], sin};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      sreg_q <= '0;
    end else if (load) begin
      sreg_q <= load_data;
    end else if (shift_en) begin
      sreg_q <= shifted;
    end
  end

  generate
    if (NARROW_W < DATA_W) begin : g_two_taps
      always_comb begin
        if (tap == TAP_NARROW) sout = sreg_q[NARROW_BIT];
        else                   sout = sreg_q[WIDE_BIT];
      end
    end else begin : g_one_tap
      assign sout = sreg_q[WIDE_BIT];
    end
  endgenerate

endmodule

// File: rtl/sdr_rxbuf.sv
module sdr_rxbuf #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [LEN_W-1:0]  len,
  input  logic              rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_full
);

  logic [DATA_W-1:0] keep_mask;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign keep_mask[i] = (len > LEN_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_done <= 1'b0;
      rx_full <= 1'b0;
    end else begin
      rx_done <= capture;
      if (capture) begin
        rx_data <= cap_data & keep_mask;
        rx_full <= 1'b1;
      end else if (rd) begin
        rx_full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_sdr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BUS_W    = 32,
  parameter int LEN_W    = 5,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              shift_strb,
  input  logic              sin,
  output logic              sout,
  output logic              busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_full,
  input  logic              rx_rd
);

  logic              accept;
  logic              shift_en;
  logic              last_shift;
  logic [LEN_W-1:0]  len_q;
  tap_e              tap_q;
  logic [DATA_W-1:0] shifted;

  // Writes count only when enabled and idle; upper bus bits are dropped
  assign accept = wr_en && enable && !busy;

  sdr_bitcnt #(
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W),
    .NARROW_W(NARROW_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .start     (accept),
    .len_in    (char_len),
    .strobe    (shift_strb),
    .busy      (busy),
    .shift_en  (shift_en),
    .last_shift(last_shift),
    .len_q     (len_q),
    .tap_q     (tap_q)
  );

  sdr_shifter #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W)
  ) u_shf (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .load     (accept),
    .load_data(wr_data[DATA_W-1:0]),
    .shift_en (shift_en),
    .sin      (sin),
    .tap      (tap_q),
    .sout     (sout),
    .shifted  (shifted)
  );

  sdr_rxbuf #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W)
  ) u_rx (
    .clk     (clk),
    .rst     (rst),
    .capture (last_shift),
    .cap_data(shifted),
    .len     (len_q),
    .rd      (rx_rd),
    .rx_data (rx_data),
    .rx_done (rx_done),
    .rx_full (rx_full)
  );

endmodule

// File: rtl/spi_sdr_checker.sv
module spi_sdr_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              wr_en,
  input logic              busy,
  input logic              sout,
  input logic              rx_done,
  input logic              rx_full,
  input logic              rx_rd,
  input logic [DATA_W-1:0] rx_data
);

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !sout)); // R11

  AST_WRITE_WHILE_OFF: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !enable) |=> !busy); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (!busy && $past(busy))); // R2

  AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> rx_full); // R10

  AST_RXDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_done |-> $stable(rx_data)); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rx_rd |=> (!rx_full || rx_done)); // R10

endmodule

bind spi_shift_core spi_sdr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .enable (enable),
  .wr_en  (wr_en),
  .busy   (busy),
  .sout   (sout),
  .rx_done(rx_done),
  .rx_full(rx_full),
  .rx_rd  (rx_rd),
  .rx_data(rx_data)
);

// File: tb/spi_shift_core_bench.sv
module spi_shift_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [4:0]  char_len = 5'd16;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        shift_strb = 1'b0;
  logic        sin = 1'b0;
  logic        rx_rd = 1'b0;
  logic        sout, busy, rx_done, rx_full;
  logic [15:0] rx_data;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  spi_shift_core u_spi_shift_core (
    .clk(clk), .rst(rst), .enable(enable), .char_len(char_len),
    .wr_en(wr_en), .wr_data(wr_data), .shift_strb(shift_strb), .sin(sin),
    .sout(sout), .busy(busy), .rx_data(rx_data), .rx_done(rx_done),
    .rx_full(rx_full), .rx_rd(rx_rd)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each completion pulse
  always @(negedge clk) begin
    if (!rst && rx_done) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: actual rx_done with data %0h expected no completion", rx_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          errors++;
          $display("FAIL R9: actual %0h expected %0h", rx_data, e);
        end
      end
    end
  end

  function automatic int eff(input logic [4:0] l);
    return (l == 0 || l > 16) ? 16 : int'(l);
  endfunction

  task automatic do_write(input logic [31:0] w, input logic [4:0] l);
    wr_data = w; char_len = l; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic shift_one(input logic s, input logic exp_out, input string req);
    check(req, {31'd0, sout}, {31'd0, exp_out});
    shift_strb = 1'b1; sin = s;
    @(negedge clk);
    shift_strb = 1'b0;
  endtask

  // Driver: loads, pushes the expected buffer value, exchanges n bits
  task automatic run_xfer(input logic [31:0] w, input logic [4:0] l,
                          input logic [15:0] rxbits, input string req,
                          input bit rd_at_end);
    int n, tap;
    logic [15:0] m;
    n   = eff(l);
    tap = (n <= 8) ? 7 : 15;
    m   = 16'((32'd1 << n) - 1);
    exp_q.push_back(rxbits & m);
    do_write(w, l);
    check("R2", {31'd0, busy}, 32'd1);
    for (int i = 0; i < n; i++) begin
      if (rd_at_end && i == n - 1) rx_rd = 1'b1;
      shift_one(rxbits[n-1-i], w[tap-i], req);
      rx_rd = 1'b0;
    end
    check("R8", {31'd0, busy}, 32'd0);
    check("R10", {31'd0, rx_full}, 32'd1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", {27'd0, sout, busy, rx_done, rx_full, 1'b0}, 32'd0);
    check("R1", {16'd0, rx_data}, 32'd0);
    enable = 1'b1;
    @(negedge clk);

    // R2 R5 R7 R9: full width, junk in upper bus half
    run_xfer(32'hDEAD_A5C3, 5'd16, 16'h3C5A, "R5", 1'b0);
    // R6: byte length, tap at bit 7
    run_xfer(32'hFFFF_00B6, 5'd8, 16'h005A, "R6", 1'b0);
    // R6 R8: 5-bit character justified at bits 7..3
    run_xfer(32'h0000_00A8, 5'd5, 16'h0013, "R6", 1'b0);
    // R5 R8: 12-bit character
    run_xfer(32'h0000_9F30, 5'd12, 16'h0ABC, "R5", 1'b0);
    // R10: read clears the flag
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    check("R10", {31'd0, rx_full}, 32'd0);
    // R8: length 0 means 16
    run_xfer(32'h0000_1234, 5'd0, 16'hFEDC, "R8", 1'b0);

    // R7: idle strobes change nothing (register holds FEDC, bit 15 = 1)
    shift_one(1'b0, 1'b1, "R7");
    shift_one(1'b0, 1'b1, "R7");
    check("R7", {31'd0, sout}, 32'd1);
    check("R7", {31'd0, busy}, 32'd0);

    // R10: completion wins over a same-cycle read
    run_xfer(32'h0000_0081, 5'd8, 16'h0066, "R10", 1'b1);

    // R4: write during transfer is dropped
    exp_q.push_back(16'h00C3);
    do_write(32'h0000_00F0, 5'd8);
    shift_one(1'b1, 1'b1, "R4");
    shift_one(1'b1, 1'b1, "R4");
    do_write(32'h0000_000F, 5'd16);
    check("R4", {31'd0, busy}, 32'd1);
    shift_one(1'b0, 1'b1, "R4");
    shift_one(1'b0, 1'b1, "R4");
    shift_one(1'b0, 1'b0, "R4");
    shift_one(1'b0, 1'b0, "R4");
    shift_one(1'b1, 1'b0, "R4");
    shift_one(1'b1, 1'b0, "R4");
    check("R4", {31'd0, busy}, 32'd0);

    // R11: abort mid-transfer
    held = rx_data;
    do_write(32'h0000_FFFF, 5'd16);
    shift_one(1'b1, 1'b1, "R11");
    shift_one(1'b1, 1'b1, "R11");
    enable = 1'b0;
    @(negedge clk);
    check("R11", {31'd0, busy}, 32'd0);
    check("R11", {31'd0, sout}, 32'd0);
    check("R11", {16'd0, rx_data}, {16'd0, held});

    // R3: write while disabled is dropped
    do_write(32'h0000_FFFF, 5'd16);
    check("R3", {31'd0, busy}, 32'd0);
    enable = 1'b1;
    @(negedge clk);
    check("R3", {30'd0, busy, sout}, 32'd0);
    repeat (3) @(negedge clk);
    check("R9", exp_q.size(), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule